// File: doc/BRIEF.md
# Ultra DMA Data-In Burst Starter (Device Side)

This block is the device end of a parallel-bus DMA read. When local logic asks for a transfer, the block raises the DMA request and waits for the host to acknowledge. It then takes the strobe line, driving it in its asserted (high) level first. Once the host has released flow control, it places the first 16-bit word on the data bus and marks that word by pulling the strobe low. Each later word is marked by the next strobe edge, so both edges carry data. Words come from a plain valid/ready source. Every interface interval is a parameter counted in clock cycles.

Each bound is counted from the host event it belongs to. The strobe turn-on delay counts from the acknowledge. The data turn-on delay and the first-edge deadline count from the "go" condition: acknowledge high, the host's stop signal low and the host's ready signal high. The data setup before any strobe edge counts from the moment the word was driven. When the host drops the acknowledge, the block releases the bus, drops the request and returns to idle. Host pauses, termination handshakes and CRC are not handled. The defaults satisfy T_ZIORDY < T_ZAD + T_DVS <= T_FS and T_DVS < T_CYC, and these relations must hold for any other parameter set.

Top module: `udma_din_starter`

## Requirements
- R1: After reset, req_o, strb_oe_o, dout_oe_o, err_o and src_ready_o are all low. When start_i is sampled high while idle, req_o is high from the next cycle.
- R2: Once raised, req_o stays high through the first strobe negation and through an error. It falls only in the cycle after ack_i is sampled low.
- R3: strb_oe_o rises exactly T_ZIORDY cycles after the first clock edge at which ack_i is sampled high. In that cycle strb_o is 1, the asserted level.
- R4: "Go" is the first edge with ack_i=1, halt_i=0 and hrdy_i=1. Later changes of halt_i and hrdy_i during the burst have no effect. The first word is accepted (src_valid_i and src_ready_o both high) at the first edge at least T_ZAD cycles after go with src_valid_i high. From that edge dout_oe_o=1 and dout_o holds the word.
- R5: The first strobe negation (strb_o going 1 to 0) happens exactly T_DVS cycles after the first word is accepted.
- R6: If no first negation has happened by the edge T_FS cycles after go, err_o rises at that edge. It stays high until the next start is accepted. The burst carries on when the word arrives.
- R7: After each strobe edge, the next word is accepted at the first edge at least T_CYC-T_DVS cycles later with src_valid_i high. strb_o toggles exactly T_DVS cycles after that acceptance and holds its level otherwise. With a continuous source, edges come every T_CYC cycles.
- R8: dout_o shows the accepted words in source order and stays stable between acceptances. src_ready_o is high only while ack_i is high.
- R9: In the cycle after ack_i is sampled low during a burst, strb_oe_o, dout_oe_o and req_o are low, and the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Local request to begin a burst |
| ack_i | input | 1 | Host DMA acknowledge, high = asserted |
| halt_i | input | 1 | Host stop signal, high = asserted |
| hrdy_i | input | 1 | Host ready-to-receive, high = asserted |
| src_data_i | input | DW | Word offered by the source |
| src_valid_i | input | 1 | Source word valid |
| src_ready_o | output | 1 | Block accepts the offered word this cycle |
| req_o | output | 1 | DMA request to the host |
| strb_o | output | 1 | Device strobe level |
| strb_oe_o | output | 1 | Strobe output enable |
| dout_o | output | DW | Data bus value |
| dout_oe_o | output | 1 | Data bus output enable |
| err_o | output | 1 | First word missed the negation deadline |

## Verification
The host acknowledge is tried immediately after the request and after a delay. "Go" is tried in the same cycle as the acknowledge, after it, and preceded by a partial state where only host-ready is high. These cases separate the strobe timing, counted from the acknowledge, from the data timing, counted from go. A source that is always valid pins the exact edge spacing. A source with random gaps shows that late words stretch the schedule without breaking the setup interval. A source held back past the deadline exposes the error flag and shows that it clears on the next start. Random stop and ready activity after go, plus an acknowledge dropped before any data, show the latched go and the release path.

// File: rtl/udma_din_pkg.sv
package udma_din_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WAIT  = 2'd1,
    PH_BURST = 2'd2
  } phase_e;

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/udma_din_rst_sync.sv
module udma_din_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/udma_din_tick.sv
module udma_din_tick #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;
  logic         sat;

  assign sat = &cnt;

  // clr with inc restarts at one: the current edge is already counted
  always_comb begin
    cnt_d = cnt;
    if (clr)             cnt_d = inc ? W'(1) : '0;
    else if (inc && !sat) cnt_d = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/udma_din_seq.sv
module udma_din_seq
  import udma_din_pkg::*;
#(
  parameter int CW       = 4,
  parameter int T_ZIORDY = 2,
  parameter int T_ZAD    = 3,
  parameter int T_DVS    = 2,
  parameter int T_FS     = 8,
  parameter int T_CYC    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          ack_i,
  input  logic          halt_i,
  input  logic          hrdy_i,
  input  logic          src_valid_i,
  input  logic          strb_oe_i,
  input  logic [CW-1:0] t_ack_i,
  input  logic [CW-1:0] t_go_i,
  input  logic [CW-1:0] t_set_i,
  input  logic [CW-1:0] t_gap_i,
  output logic          ack_clr_o,
  output logic          ack_inc_o,
  output logic          go_clr_o,
  output logic          go_inc_o,
  output logic          set_clr_o,
  output logic          set_inc_o,
  output logic          gap_clr_o,
  output logic          gap_inc_o,
  output logic          release_o,
  output logic          strb_en_o,
  output logic          load_o,
  output logic          toggle_o,
  output logic          ready_o,
  output logic          req_o,
  output logic          err_o
);
  localparam logic [CW-1:0] LIM_ZIO = CW'(T_ZIORDY);
  localparam logic [CW-1:0] LIM_ZAD = CW'(T_ZAD);
  localparam logic [CW-1:0] LIM_DVS = CW'(T_DVS);
  localparam logic [CW-1:0] LIM_FS  = CW'(T_FS);
  localparam logic [CW-1:0] LIM_GAP = CW'(T_CYC - T_DVS);

  phase_e ph_q, ph_d;
  logic   req_q, req_d;
  logic   err_q, err_d;
  logic   go_seen_q, go_seen_d;
  logic   pend_q, pend_d;
  logic   neg_done_q, neg_done_d;

  logic   active, go_now, go_act, miss;

  assign active = (ph_q != PH_IDLE) && ack_i;
  assign go_now = ack_i && !halt_i && hrdy_i;
  assign go_act = active && (go_seen_q || go_now);

  assign strb_en_o = active && (t_ack_i >= LIM_ZIO);
  assign ready_o   = active && !pend_q &&
                     (neg_done_q ? (t_gap_i >= LIM_GAP)
                                 : (go_act && (t_go_i >= LIM_ZAD)));
  assign load_o    = ready_o && src_valid_i;
  assign toggle_o  = active && pend_q && strb_oe_i && (t_set_i >= LIM_DVS);
  assign miss      = go_act && !neg_done_q && !toggle_o && (t_go_i >= LIM_FS);
  assign release_o = !active;

  // interval counters
  assign ack_clr_o = !active;
  assign ack_inc_o = active;
  assign go_clr_o  = !active;
  assign go_inc_o  = go_act;
  assign set_clr_o = !active || load_o;
  assign set_inc_o = load_o || (active && pend_q);
  assign gap_clr_o = !active || toggle_o;
  assign gap_inc_o = toggle_o || (active && neg_done_q);

  always_comb begin
    ph_d       = ph_q;
    req_d      = req_q;
    err_d      = err_q;
    go_seen_d  = go_seen_q;
    pend_d     = pend_q;
    neg_done_d = neg_done_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (start_i) begin
          ph_d  = PH_WAIT;
          req_d = 1'b1;
          err_d = 1'b0;
        end
      end
      PH_WAIT: begin
        if (ack_i) ph_d = PH_BURST;
      end
      PH_BURST: begin
        if (!ack_i) begin
          ph_d  = PH_IDLE;
          req_d = 1'b0;
        end
      end
      default: begin
        ph_d  = PH_IDLE;
        req_d = 1'b0;
      end
    endcase
    if (!active) begin
      go_seen_d  = 1'b0;
      pend_d     = 1'b0;
      neg_done_d = 1'b0;
    end else begin
      if (go_now)        go_seen_d  = 1'b1;
      if (load_o)        pend_d     = 1'b1;
      else if (toggle_o) pend_d     = 1'b0;
      if (toggle_o)      neg_done_d = 1'b1;
      if (miss)          err_d      = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PH_IDLE;
      req_q      <= 1'b0;
      err_q      <= 1'b0;
      go_seen_q  <= 1'b0;
      pend_q     <= 1'b0;
      neg_done_q <= 1'b0;
    end else begin
      ph_q       <= ph_d;
      req_q      <= req_d;
      err_q      <= err_d;
      go_seen_q  <= go_seen_d;
      pend_q     <= pend_d;
      neg_done_q <= neg_done_d;
    end
  end

  assign req_o = req_q;
  assign err_o = err_q;
endmodule

// File: rtl/udma_din_lane.sv
module udma_din_lane #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          release_i,
  input  logic          strb_en_i,
  input  logic          toggle_i,
  input  logic          load_i,
  input  logic [DW-1:0] word_i,
  output logic          strb_o,
  output logic          strb_oe_o,
  output logic [DW-1:0] dout_o,
  output logic          dout_oe_o
);
  logic strb_q, strb_d;
  logic soe_q, soe_d;
  logic doe_q, doe_d;
  logic [DW-1:0] data_q;

  always_comb begin
    strb_d = strb_q;
    soe_d  = soe_q;
    doe_d  = doe_q;
    if (release_i) begin
      strb_d = 1'b1;
      soe_d  = 1'b0;
      doe_d  = 1'b0;
    end else begin
      if (strb_en_i && !soe_q) begin
        soe_d  = 1'b1;
        strb_d = 1'b1;
      end
      if (toggle_i) strb_d = !strb_q;
      if (load_i)   doe_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= 1'b1;
      soe_q  <= 1'b0;
      doe_q  <= 1'b0;
    end else begin
      strb_q <= strb_d;
      soe_q  <= soe_d;
      doe_q  <= doe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (load_i) data_q <= word_i;
  end

  assign strb_o    = strb_q;
  assign strb_oe_o = soe_q;
  assign dout_o    = data_q;
  assign dout_oe_o = doe_q;
endmodule

// File: rtl/udma_din_starter.sv
module udma_din_starter
  import udma_din_pkg::*;
#(
  parameter int DW       = 16,
  parameter int T_ZIORDY = 2,
  parameter int T_ZAD    = 3,
  parameter int T_DVS    = 2,
  parameter int T_FS     = 8,
  parameter int T_CYC    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          ack_i,
  input  logic          halt_i,
  input  logic          hrdy_i,
  input  logic [DW-1:0] src_data_i,
  input  logic          src_valid_i,
  output logic          src_ready_o,
  output logic          req_o,
  output logic          strb_o,
  output logic          strb_oe_o,
  output logic [DW-1:0] dout_o,
  output logic          dout_oe_o,
  output logic          err_o
);
  localparam int TMAX = int'(max_of4(T_ZIORDY, T_ZAD + T_DVS, T_FS, T_CYC));
  localparam int CW   = $clog2(TMAX + 2);
  localparam int NTMR = 4;

  logic rst_sync_n;
  logic release_w, strb_en_w, load_w, toggle_w;
  logic [NTMR-1:0] tmr_clr, tmr_inc;
  logic [CW-1:0]   tmr_cnt [NTMR];

  udma_din_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // 0: since acknowledge, 1: since go, 2: since word driven, 3: since last edge
  for (genvar gi = 0; gi < NTMR; gi++) begin : g_tmr
    udma_din_tick #(.W(CW)) u_tick (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .clr   (tmr_clr[gi]),
      .inc   (tmr_inc[gi]),
      .cnt   (tmr_cnt[gi])
    );
  end

  udma_din_seq #(
    .CW(CW), .T_ZIORDY(T_ZIORDY), .T_ZAD(T_ZAD),
    .T_DVS(T_DVS), .T_FS(T_FS), .T_CYC(T_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start_i     (start_i),
    .ack_i       (ack_i),
    .halt_i      (halt_i),
    .hrdy_i      (hrdy_i),
    .src_valid_i (src_valid_i),
    .strb_oe_i   (strb_oe_o),
    .t_ack_i     (tmr_cnt[0]),
    .t_go_i      (tmr_cnt[1]),
    .t_set_i     (tmr_cnt[2]),
    .t_gap_i     (tmr_cnt[3]),
    .ack_clr_o   (tmr_clr[0]),
    .ack_inc_o   (tmr_inc[0]),
    .go_clr_o    (tmr_clr[1]),
    .go_inc_o    (tmr_inc[1]),
    .set_clr_o   (tmr_clr[2]),
    .set_inc_o   (tmr_inc[2]),
    .gap_clr_o   (tmr_clr[3]),
    .gap_inc_o   (tmr_inc[3]),
    .release_o   (release_w),
    .strb_en_o   (strb_en_w),
    .load_o      (load_w),
    .toggle_o    (toggle_w),
    .ready_o     (src_ready_o),
    .req_o       (req_o),
    .err_o       (err_o)
  );

  udma_din_lane #(.DW(DW)) u_lane (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .release_i (release_w),
    .strb_en_i (strb_en_w),
    .toggle_i  (toggle_w),
    .load_i    (load_w),
    .word_i    (src_data_i),
    .strb_o    (strb_o),
    .strb_oe_o (strb_oe_o),
    .dout_o    (dout_o),
    .dout_oe_o (dout_oe_o)
  );
endmodule

// File: rtl/udma_din_sva.sv
module udma_din_sva (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic ack_i,
  input logic src_valid_i,
  input logic src_ready_o,
  input logic req_o,
  input logic strb_o,
  input logic strb_oe_o,
  input logic dout_oe_o,
  input logic err_o
);
  a_r1_req_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> $past(start_i));

  a_r2_req_until_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_o) |-> !$past(ack_i));

  a_r3_strobe_starts_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strb_oe_o) |-> strb_o);

  a_r5_edge_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_oe_o && $past(strb_oe_o) && (strb_o != $past(strb_o))) |-> $past(dout_oe_o));

  a_r6_err_while_requesting: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> req_o);

  a_r8_word_by_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe_o) |-> $past(src_valid_i && src_ready_o));

  a_r8_ready_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready_o |-> ack_i);

  a_r9_strobe_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strb_oe_o) |-> !$past(ack_i));
endmodule

bind udma_din_starter udma_din_sva u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .ack_i       (ack_i),
  .src_valid_i (src_valid_i),
  .src_ready_o (src_ready_o),
  .req_o       (req_o),
  .strb_o      (strb_o),
  .strb_oe_o   (strb_oe_o),
  .dout_oe_o   (dout_oe_o),
  .err_o       (err_o)
);

// File: tb/tb_udma_din_starter.sv
`timescale 1ns/1ps
module tb_udma_din_starter;
  localparam int DW = 16;
  localparam int T_ZIORDY = 2;
  localparam int T_ZAD = 3;
  localparam int T_DVS = 2;
  localparam int T_FS = 8;
  localparam int T_CYC = 4;

  logic clk, rst_n, start_i, ack_i, halt_i, hrdy_i;
  logic [DW-1:0] src_data_i, dout_o;
  logic src_valid_i, src_ready_o, req_o, strb_o, strb_oe_o, dout_oe_o, err_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int vprob = 0;

  udma_din_starter #(.DW(DW), .T_ZIORDY(T_ZIORDY), .T_ZAD(T_ZAD), .T_DVS(T_DVS),
                     .T_FS(T_FS), .T_CYC(T_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ack_i(ack_i), .halt_i(halt_i),
    .hrdy_i(hrdy_i), .src_data_i(src_data_i), .src_valid_i(src_valid_i),
    .src_ready_o(src_ready_o), .req_o(req_o), .strb_o(strb_o), .strb_oe_o(strb_oe_o),
    .dout_o(dout_o), .dout_oe_o(dout_oe_o), .err_o(err_o));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [DW-1:0] word_of(input int i);
    return DW'((i * 40503 + 12345) ^ (i >> 3));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // source driver: decides after the negedge, so ready has settled
  int  src_idx = 0;
  bit  hs = 0;
  initial begin
    src_valid_i = 1'b0;
    src_data_i  = word_of(0);
    forever begin
      @(negedge clk); #1;
      if (hs) src_idx++;
      src_valid_i = int'($urandom % 100) < vprob;
      src_data_i  = word_of(src_idx);
      hs = src_valid_i && src_ready_o;
    end
  end

  // monitor: expected schedule from the requirements, sampled 2 ns after each edge
  typedef enum {M_IDLE, M_WAIT, M_BURST} mst_t;
  mst_t mst = M_IDLE;
  int cyc = 0, ack_e, go_e, load_e, last_e, exp_idx = 0;
  bit go_seen, pend, neg_done, have_word, exp_err = 0, prev_strb;
  logic [DW-1:0] cur_word;

  initial begin
    bit a, g, v, tog, ld;
    wait (rst_n === 1'b1);
    forever begin
      @(posedge clk); #2;
      cyc++;
      a = ack_i; g = ack_i && !halt_i && hrdy_i; v = src_valid_i;
      if (mst == M_IDLE) begin
        if (start_i) begin
          mst = M_WAIT; exp_err = 0;
          chk(req_o === 1'b1, "R1 request after start", req_o, 1);
        end else
          chk(!req_o && !strb_oe_o && !dout_oe_o, "R1 idle outputs",
              {req_o, strb_oe_o, dout_oe_o}, 0);
        chk(err_o === exp_err, "R6 flag", err_o, exp_err);
      end else if (mst == M_WAIT) begin
        if (a) begin
          mst = M_BURST; ack_e = cyc; go_seen = 0; pend = 0; neg_done = 0; have_word = 0;
        end else
          chk(req_o && !strb_oe_o && !dout_oe_o, "R2 waiting", {req_o, strb_oe_o, dout_oe_o}, 4);
      end
      if (mst == M_BURST) begin
        if (!a) begin
          chk(!req_o && !strb_oe_o && !dout_oe_o, "R9 release", {req_o, strb_oe_o, dout_oe_o}, 0);
          mst = M_IDLE;
        end else begin
          if (!go_seen && g) begin go_seen = 1; go_e = cyc; end
          tog = pend && (cyc == load_e + T_DVS);
          ld  = !pend && v && (neg_done ? (cyc >= last_e + T_CYC - T_DVS)
                                        : (go_seen && cyc >= go_e + T_ZAD));
          if (cyc < ack_e + T_ZIORDY)
            chk(!strb_oe_o, "R3 strobe too early", strb_oe_o, 0);
          else if (cyc == ack_e + T_ZIORDY)
            chk(strb_oe_o && strb_o, "R3 strobe on high", {strb_oe_o, strb_o}, 3);
          if (tog) begin
            chk(strb_oe_o && strb_o != prev_strb, neg_done ? "R7 edge" : "R5 first negation",
                strb_o, !prev_strb);
            if (!neg_done) chk(prev_strb == 1'b1, "R5 negation from high", prev_strb, 1);
            pend = 0; last_e = cyc; neg_done = 1;
          end else if (cyc > ack_e + T_ZIORDY)
            chk(strb_o == prev_strb, "R7 strobe hold", strb_o, prev_strb);
          if (ld) begin
            chk(dout_oe_o && dout_o == word_of(exp_idx), neg_done ? "R7 next word" : "R4 first word",
                {15'd0, dout_oe_o, dout_o}, {16'd1, word_of(exp_idx)});
            cur_word = word_of(exp_idx); exp_idx++; pend = 1; load_e = cyc; have_word = 1;
          end else if (have_word)
            chk(dout_oe_o && dout_o == cur_word, "R8 word stable", dout_o, cur_word);
          else
            chk(!dout_oe_o, "R4 data too early", dout_oe_o, 0);
          if (go_seen && !neg_done && cyc >= go_e + T_FS) exp_err = 1;
          chk(err_o === exp_err, "R6 deadline", err_o, exp_err);
          chk(req_o === 1'b1, "R2 request held", req_o, 1);
        end
      end
      prev_strb = strb_o;
    end
  end

  task automatic run_burst(input int ack_dly, input int go_dly, input int len,
                           input int vp, input int vstart, input bit jitter);
    vprob = 0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (ack_dly) @(negedge clk);
    ack_i = 1'b1; halt_i = 1'b1; hrdy_i = 1'b0;
    for (int c = 0; c < len; c++) begin
      if (c == vstart) vprob = vp;
      if (c == go_dly) begin halt_i = 1'b0; hrdy_i = 1'b1; end
      else if (go_dly > 1 && c == go_dly / 2) hrdy_i = 1'b1;
      else if (jitter && c > go_dly) begin
        halt_i = ($urandom % 6) == 0;   // R4: ignored after go
        hrdy_i = ($urandom % 6) != 0;
      end
      @(negedge clk);
    end
    ack_i = 1'b0; halt_i = 1'b1; hrdy_i = 1'b0; vprob = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 1'b0; ack_i = 1'b0; halt_i = 1'b1; hrdy_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!req_o && !strb_oe_o && !dout_oe_o && !err_o && !src_ready_o, "R1 reset state",
        {req_o, strb_oe_o, dout_oe_o, err_o, src_ready_o}, 0);
    run_burst(1, 0, 30, 100, 0, 0);   // R5 R7 exact spacing, go with acknowledge
    run_burst(0, 4, 30, 100, 0, 0);   // R4 go later, partial ready first
    run_burst(2, 0, 40, 100, 12, 0);  // R6 source late past deadline
    run_burst(1, 0, 20, 100, 0, 1);   // R6 cleared by new start, R4 jitter
    run_burst(0, 0, 3, 100, 0, 0);    // R9 drop before any data
    run_burst(3, 2, 25, 40, 0, 1);    // R7 gappy source
    for (int b = 0; b < 40; b++)
      run_burst(int'($urandom % 5), int'($urandom % 6), 10 + int'($urandom % 50),
                30 + int'($urandom % 71), int'($urandom % 14), 1'($urandom % 2));
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule